// File: doc/BRIEF.md
# Clock Timer with Interrupt Flags

This block counts a 256 Hz enable tick through an eight-stage binary divider. Each stage is a tap running at half the rate of the one below it, from 128 Hz down to 1 Hz. Software reads the eight tap bits as two 4-bit words on a small register bus. The bus has an address, a write strobe, a read strobe and 4-bit data. Read data is combinational in the cycle the read strobe is high.

Four of the taps raise latched interrupt flags when they fall: 32 Hz, 8 Hz, 2 Hz and 1 Hz. A read of the flag word clears the flags. Each flag has its own enable bit. The enabled flags are ORed into one interrupt request. The enable bits can be written only while the processor's interrupt-enable input is low.

A write-only strobe bit clears the whole divider. The same strobe emits a one-cycle pulse that tells an external watchdog to restart.

Top module: `clock_timer_irq`

## Requirements
- R1: On each cycle with `tick_256` high, the divider value increments by one modulo 256. Tap k is bit k of this value: bit 0 is 128 Hz and bit 7 is 1 Hz.
- R2: Address 0xE3 reads the low four taps, with the 128 Hz tap in D0. Address 0xE4 reads the high four taps, with the 1 Hz tap in D3. Writes to either address leave the divider unchanged.
- R3: After reset, the divider, all flags and all enable bits are 0, and `irq` and `wdt_clear` are low.
- R4: A flag is set in the cycle its tap changes from 1 to 0 on a tick. Address 0xC6 reads the flags with 1 Hz in D3, 2 Hz in D2, 8 Hz in D1 and 32 Hz in D0.
- R5: Reading 0xC6 clears every flag at the next clock edge. If a tap falls on that same edge, its flag stays set.
- R6: Address 0xCC holds the enable bits, in the same bit layout as 0xC6, and reads them back. A write there updates them only while `cpu_ie` is 0. A write while `cpu_ie` is 1 is ignored.
- R7: `irq` is high exactly when at least one flag and its enable bit are both 1.
- R8: Writing 0xE2 with D1 set clears the divider to 0 and sets no flag. The same write drives `wdt_clear` high for the one following cycle. A write to 0xE2 with D1 clear does nothing. 0xE2 always reads 0.
- R9: Every address other than 0xC6, 0xCC, 0xE3 and 0xE4 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_256 | input | 1 | 256 Hz enable, one cycle wide |
| cpu_ie | input | 1 | Processor interrupt-enable state |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe (clears flags at 0xC6) |
| bus_rdata | output | DATA_W | Read data, same cycle |
| irq | output | 1 | Interrupt request |
| wdt_clear | output | 1 | One-cycle watchdog restart pulse |

## Verification
The bench builds the block with its defaults: eight stages, an 8-bit address and 4-bit data. With these values a full divider cycle takes 256 ticks, so a complete wrap in which all four flag sources fall together is within reach. Clearing the divider from the all-ones state is also within reach; there the clear drops every tap at once, and no flag may appear. The bench also forces a tap to fall on the same edge as a flag read, to show that the new flag survives the clear.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
    // Register addresses decoded on the bus
    localparam logic [7:0] CT_ADDR_FLAG  = 8'hC6;
    localparam logic [7:0] CT_ADDR_MASK  = 8'hCC;
    localparam logic [7:0] CT_ADDR_RST   = 8'hE2;
    localparam logic [7:0] CT_ADDR_TAPLO = 8'hE3;
    localparam logic [7:0] CT_ADDR_TAPHI = 8'hE4;
    // Bit of the reset register that carries the strobe
    localparam int CT_RST_BIT = 1;
    // Tap indices feeding the four flags (flag bit order 0..3)
    localparam int CT_TAP_32HZ = 2;
    localparam int CT_TAP_8HZ  = 4;
    localparam int CT_TAP_2HZ  = 6;
    localparam int CT_TAP_1HZ  = 7;
    localparam int CT_NSRC     = 4;
endpackage

// File: rtl/ctmr_divider.sv
module ctmr_divider #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    output logic [STAGES-1:0] taps,
    output logic [STAGES-1:0] falls
);
    typedef struct packed {
        logic [STAGES-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        falls = '0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + STAGES'(1);
            falls    = st_q.cnt & ~st_d.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taps = st_q.cnt;

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (taps == '0));
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (taps == $past(taps) + STAGES'(1)));
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(taps));
endmodule

// File: rtl/ctmr_flags.sv
module ctmr_flags #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic            rd_clr,
    output logic [NSRC-1:0] flags
);
    typedef struct packed {
        logic [NSRC-1:0] flg;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr) st_d.flg = '0;
        st_d.flg = st_d.flg | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;

    assert_rdclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set == '0) |=> (flags == '0));
    assert_setwin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags & $past(set)) == $past(set)));
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/clock_timer_irq.sv
module clock_timer_irq
    import ctmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4,
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_256,
    input  logic              cpu_ie,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_clear
);
    localparam int HALF = STAGES / 2;

    typedef struct packed {
        logic [CT_NSRC-1:0] mask;
        logic               wdt;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [STAGES-1:0]  taps, falls;
    logic [CT_NSRC-1:0] flag_set, flags;
    logic               hit_flag, hit_mask, hit_rst, hit_lo, hit_hi;
    logic               mask_wr, tmrst_hit, flag_rd;
    logic               falls_unused;

    assign hit_flag = (bus_addr == ADDR_W'(CT_ADDR_FLAG));
    assign hit_mask = (bus_addr == ADDR_W'(CT_ADDR_MASK));
    assign hit_rst  = (bus_addr == ADDR_W'(CT_ADDR_RST));
    assign hit_lo   = (bus_addr == ADDR_W'(CT_ADDR_TAPLO));
    assign hit_hi   = (bus_addr == ADDR_W'(CT_ADDR_TAPHI));

    assign mask_wr   = bus_wr && hit_mask;
    assign tmrst_hit = bus_wr && hit_rst && bus_wdata[CT_RST_BIT];
    assign flag_rd   = bus_rd && hit_flag;

    ctmr_divider #(.STAGES(STAGES)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_256),
        .clr   (tmrst_hit),
        .taps  (taps),
        .falls (falls)
    );

    assign flag_set = {falls[CT_TAP_1HZ], falls[CT_TAP_2HZ],
                       falls[CT_TAP_8HZ], falls[CT_TAP_32HZ]};
    assign falls_unused = ^{falls[0], falls[1], falls[3], falls[5]};

    ctmr_flags #(.NSRC(CT_NSRC)) u_flg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (flag_set),
        .rd_clr (flag_rd),
        .flags  (flags)
    );

    always_comb begin
        st_d     = st_q;
        st_d.wdt = tmrst_hit;
        if (mask_wr && !cpu_ie) st_d.mask = bus_wdata[CT_NSRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_flag)    bus_rdata = DATA_W'(flags);
        else if (hit_mask) bus_rdata = DATA_W'(st_q.mask);
        else if (hit_lo) bus_rdata = DATA_W'(taps[HALF-1:0]);
        else if (hit_hi) bus_rdata = DATA_W'(taps[STAGES-1:HALF]);
    end

    assign irq       = |(flags & st_q.mask);
    assign wdt_clear = st_q.wdt;

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && cpu_ie) |=> $stable(st_q.mask));
    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !cpu_ie) |=> (st_q.mask == $past(bus_wdata[CT_NSRC-1:0])));
    assert_wdt_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmrst_hit |=> wdt_clear);
    assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0 && st_q.mask != '0));
    assert_rst_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rst |-> (bus_rdata == '0));
endmodule

// File: tb/sim_clock_timer_irq.sv
`timescale 1ns/1ps
module sim_clock_timer_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_256 = 1'b0;
    logic       cpu_ie = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = 4'h0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_rdata;
    logic       irq, wdt_clear;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clock_timer_irq u0 (
        .clk(clk), .rst_n(rst_n), .tick_256(tick_256), .cpu_ie(cpu_ie),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq), .wdt_clear(wdt_clear)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_256 = 1'b1;
            @(negedge clk) tick_256 = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [3:0] d;
        check("R3 irq", irq, 0);
        check("R3 wdt_clear", wdt_clear, 0);
        rd(8'hE3, d); check("R3 taps lo", d, 0);
        rd(8'hE4, d); check("R3 taps hi", d, 0);
        rd(8'hC6, d); check("R3 flags", d, 0);
        rd(8'hCC, d); check("R3 mask", d, 0);
    endtask

    task automatic t_count();
        logic [3:0] d;
        ticks(5);
        rd(8'hE3, d); check("R1 lo after 5", d, 5);
        rd(8'hE4, d); check("R2 hi after 5", d, 0);
        rd(8'hC6, d); check("R4 no flag before fall", d, 0);
        ticks(3);
        rd(8'hE3, d); check("R1 lo after 8", d, 8);
        rd(8'hC6, d); check("R4 32Hz flag in D0", d, 4'h1);
        rd(8'hC6, d); check("R5 cleared by read", d, 0);
        wr(8'hE3, 4'hF);
        wr(8'hE4, 4'hF);
        rd(8'hE3, d); check("R2 write ignored lo", d, 8);
        rd(8'hE4, d); check("R2 write ignored hi", d, 0);
        rd(8'h55, d); check("R9 unmapped reads 0", d, 0);
    endtask

    task automatic t_mask();
        logic [3:0] d;
        cpu_ie = 1'b1;
        wr(8'hCC, 4'hF);
        rd(8'hCC, d); check("R6 write blocked while ie", d, 0);
        cpu_ie = 1'b0;
        wr(8'hCC, 4'h5);
        rd(8'hCC, d); check("R6 write accepted", d, 5);
    endtask

    task automatic t_irq();
        logic [3:0] d;
        ticks(8);                   // 8 -> 16, 32 Hz tap falls
        #1 check("R7 irq enabled flag", irq, 1);
        rd(8'hC6, d); check("R4 32Hz at 16", d, 4'h1);
        #1 check("R7 irq drops after clear", irq, 0);
        wr(8'hCC, 4'h0);
        ticks(8);                   // 16 -> 24
        rd(8'hC6, d); check("R7 masked flag present", d, 4'h1);
        check("R7 irq masked", irq, 0);
    endtask

    task automatic t_setwins();
        logic [3:0] d;
        ticks(7);                   // 24 -> 31
        rd(8'hC6, d); check("R5 empty before", d, 0);
        @(negedge clk);
        bus_addr = 8'hC6; bus_rd = 1'b1; tick_256 = 1'b1;   // 31 -> 32 with read
        #1 d = bus_rdata;
        check("R5 read value same cycle", d, 0);
        @(negedge clk);
        bus_rd = 1'b0; tick_256 = 1'b0;
        rd(8'hC6, d); check("R5 set beats clear (8Hz,32Hz)", d, 4'h3);
    endtask

    task automatic t_tmrst();
        logic [3:0] d;
        ticks(223);                 // 32 -> 255
        rd(8'hE3, d); check("R1 lo at 255", d, 4'hF);
        rd(8'hE4, d); check("R1 hi at 255", d, 4'hF);
        rd(8'hC6, d);               // drain flags
        wr(8'hE2, 4'hD);            // D1 clear: no action
        check("R8 no pulse without D1", wdt_clear, 0);
        rd(8'hE3, d); check("R8 no clear without D1", d, 4'hF);
        @(negedge clk);
        bus_addr = 8'hE2; bus_wdata = 4'h2; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 wdt pulse high", wdt_clear, 1);
        @(negedge clk);
        check("R8 wdt pulse one cycle", wdt_clear, 0);
        rd(8'hE3, d); check("R8 lo cleared", d, 0);
        rd(8'hE4, d); check("R8 hi cleared", d, 0);
        rd(8'hC6, d); check("R8 clear sets no flag", d, 0);
        rd(8'hE2, d); check("R8 reads 0", d, 0);
    endtask

    task automatic t_wrap();
        logic [3:0] d;
        ticks(256);
        rd(8'hE3, d); check("R1 wrap lo", d, 0);
        rd(8'hE4, d); check("R1 wrap hi", d, 0);
        rd(8'hC6, d); check("R4 all four flags", d, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_mask();
        t_irq();
        t_setwins();
        t_tmrst();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule